// File: doc/BRIEF.md
# Legacy Shadow Window Access Router

This block sits on the memory request path and picks a target for every read or write whose address lands in the legacy firmware shadow window, 0D8000h up to 0EFFFFh. The window is split into six consecutive 16 KB segments. Each segment has a 2-bit attribute that sets, on its own terms, whether reads and whether writes in that segment go to main memory or to the downstream legacy port. Because of this, a read and a write to the same address can end up at different targets, and firmware can copy itself into shadow memory and then lock it read-only.

The six attributes live in one 32-bit configuration word. Software reaches that word through a small register port with per-byte write enables. The transaction side takes an address, a direction flag and a valid strobe. One clock later it returns a registered decision: main memory, or the legacy port.

Top module: `shadow_router`

## Requirements
- R1: After reset the configuration word reads as 0, and every access in the window, read or write, routes to the legacy port (`txn_to_mem` = 0).
- R2: The attribute fields sit at word bits [1:0], [5:4], [9:8], [13:12], [17:16] and [21:20]. They cover, in that order, the 16 KB segments that start at 0D8000h, 0DC000h, 0E0000h, 0E4000h, 0E8000h and 0EC000h.
- R3: Attribute 00 sends both reads and writes in its segment to the legacy port.
- R4: Attribute 01 sends reads to memory and writes to the legacy port.
- R5: Attribute 10 sends writes to memory and reads to the legacy port.
- R6: Attribute 11 sends both reads and writes in its segment to memory.
- R7: Any address below 0D8000h or above 0EFFFFh routes to memory, whatever the attributes hold.
- R8: A register write changes only the bytes whose enable bit is set (`cfg_be[i]` covers bits [8i+7:8i]).
- R9: All bits outside the six fields read as 0, and writes to them are ignored.
- R10: When `txn_valid` is high in cycle N, `txn_done` is high in cycle N+1 and carries that request's decision. `txn_done` is low in every cycle that does not follow a valid request.
- R11: The decision uses the attributes as they stood in cycle N, even if a register write takes effect at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Current configuration word |
| txn_valid | input | 1 | Request strobe |
| txn_addr | input | ADDR_W | Request byte address |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_done | output | 1 | Decision valid, one cycle after the request |
| txn_to_mem | output | 1 | 1 = main memory, 0 = legacy port |

## Verification
The hardest case to reach is a request accepted at the same edge where a register write changes that request's segment attribute. The decision must follow the old value, not the new one. The stimulus drives `txn_valid` and `cfg_we` together in one cycle and flips the attribute of the addressed segment. It does this in both directions, opening the segment to memory and closing it again. The scoreboard holds the expected route taken from the model's attributes before the write. The segment edges at 0D7FFFh/0D8000h and 0EFFFFh/0F0000h, and each segment's first and last byte, are swept under all four attribute codes.

// File: rtl/shadow_router.sv
module shadow_router #(
  parameter int ADDR_W   = 32,
  parameter int NUM_SEG  = 6,
  parameter int SEG_BITS = 14,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'h0D8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              txn_valid,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic              txn_write,
  output logic              txn_done,
  output logic              txn_to_mem
);
  localparam logic [ADDR_W-1:0] WIN_SIZE = ADDR_W'(NUM_SEG) << SEG_BITS;
  localparam logic [ADDR_W-1:0] WIN_END  = WIN_BASE + WIN_SIZE;
  localparam int IDX_W = $clog2(NUM_SEG);

  logic [31:0] field_mask;
  logic [31:0] byte_mask;
  logic [31:0] attr_q;

  always_comb begin
    field_mask = '0;
    for (int s = 0; s < NUM_SEG; s++) field_mask[4*s +: 2] = 2'b11;
  end

  for (genvar b = 0; b < 4; b++) begin : g_be
    assign byte_mask[8*b +: 8] = {8{cfg_be[b]}};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) attr_q <= '0;
    else if (cfg_we)
      attr_q <= ((attr_q & ~byte_mask) | (cfg_wdata & byte_mask)) & field_mask;

  assign cfg_rdata = attr_q;

  logic              in_win;
  logic [ADDR_W-1:0] offs;
  logic [IDX_W-1:0]  seg;
  logic [1:0]        attr;
  logic              route;

  assign in_win = (txn_addr >= WIN_BASE) && (txn_addr < WIN_END);
  assign offs   = txn_addr - WIN_BASE;
  assign seg    = IDX_W'(offs >> SEG_BITS);
  assign attr   = attr_q[4*seg +: 2];
  assign route  = !in_win ? 1'b1 : (txn_write ? attr[1] : attr[0]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      txn_done   <= 1'b0;
      txn_to_mem <= 1'b0;
    end else begin
      txn_done <= txn_valid;
      if (txn_valid) txn_to_mem <= route;
    end

  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~field_mask) == 32'h0);
  // R10
  done_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |=> txn_done);
  // R10
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_valid |=> !txn_done);
  // R7
  outside_to_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && (txn_addr < WIN_BASE || txn_addr >= WIN_END)) |=> txn_to_mem);
  // R8
  unselected_bytes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_be == 4'b0) |=> $stable(cfg_rdata));
  // R3
  disabled_to_legacy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && in_win && attr == 2'b00) |=> !txn_to_mem);
endmodule

// File: tb/shadow_router_bench.sv
module shadow_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [3:0] cfg_be = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic txn_valid = 0, txn_write = 0;
  logic [AW-1:0] txn_addr = 0;
  logic txn_done, txn_to_mem;

  int checks = 0, errors = 0;
  logic [31:0] model = 0;
  bit  exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_router u_shadow_router (.*);

  function automatic bit exp_route(logic [31:0] m, logic [AW-1:0] a, bit w);
    int s;
    logic [1:0] at;
    if (a < 32'h0D8000 || a > 32'h0EFFFF) return 1'b1;
    s = int'((a - 32'h0D8000) >> 14);
    at = m[4*s +: 2];
    return w ? at[1] : at[0];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [3:0] be, logic [31:0] d);
    logic [31:0] bm;
    for (int b = 0; b < 4; b++) bm[8*b +: 8] = {8{be[b]}};
    @(negedge clk);
    cfg_we = 1; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    model = ((model & ~bm) | (d & bm)) & 32'h0033_3333;
  endtask

  task automatic txn(logic [AW-1:0] a, bit w, string req);
    @(negedge clk);
    txn_valid = 1; txn_addr = a; txn_write = w;
    exp_q.push_back(exp_route(model, a, w));
    tag_q.push_back(req);
    @(negedge clk);
    txn_valid = 0;
  endtask

  // monitor: sample at negedge, away from the active edge
  always @(negedge clk) begin
    if (rst_n && txn_done) begin
      if (exp_q.size() == 0) check("R10", 1, 0);
      else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, txn_to_mem, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [31:0] SEG_BASE [6] = '{32'h0D8000, 32'h0DC000, 32'h0E0000,
                                           32'h0E4000, 32'h0E8000, 32'h0EC000};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", cfg_rdata, 32'h0);
    check("R1", {31'b0, txn_done}, 0);
    txn(32'h0D8000, 0, "R1");
    txn(32'h0EFFFF, 1, "R1");

    // R2..R6: each code on each segment, first and last byte, both directions
    for (int code = 0; code < 4; code++) begin
      for (int s = 0; s < 6; s++) begin
        logic [31:0] w;
        string rq;
        w = model;
        w[4*s +: 2] = 2'(code);
        cfg_write(4'hF, w);
        rq = (code == 0) ? "R3" : (code == 1) ? "R4" : (code == 2) ? "R5" : "R6";
        txn(SEG_BASE[s], 0, rq);
        txn(SEG_BASE[s], 1, rq);
        txn(SEG_BASE[s] + 32'h3FFF, 0, "R2");
        txn(SEG_BASE[s] + 32'h3FFF, 1, "R2");
      end
    end

    // R2 distinct codes per segment
    cfg_write(4'hF, 32'h0012_3012);
    check("R2", cfg_rdata, 32'h0012_3012);
    for (int s = 0; s < 6; s++) begin
      txn(SEG_BASE[s] + 32'h1234, 0, "R2");
      txn(SEG_BASE[s] + 32'h1234, 1, "R2");
    end

    // R7 outside window, including edges
    cfg_write(4'hF, 32'h0);
    txn(32'h0D7FFF, 0, "R7");
    txn(32'h0D7FFF, 1, "R7");
    txn(32'h0F0000, 0, "R7");
    txn(32'h0F0000, 1, "R7");
    txn(32'h0000_0000, 1, "R7");
    txn(32'hFFFF_FFFF, 0, "R7");

    // R8 byte enables
    cfg_write(4'hF, 32'h0);
    cfg_write(4'b0100, 32'hFFFF_FFFF);
    check("R8", cfg_rdata, 32'h0033_0000);
    cfg_write(4'b0001, 32'h0000_0011);
    check("R8", cfg_rdata, 32'h0033_0011);
    cfg_write(4'b0000, 32'h0);
    check("R8", cfg_rdata, 32'h0033_0011);
    txn(32'h0E8000, 0, "R8");
    txn(32'h0E0000, 1, "R8");

    // R9 reserved bits
    cfg_write(4'hF, 32'hFFFF_FFFF);
    check("R9", cfg_rdata, 32'h0033_3333);
    cfg_write(4'b1000, 32'h0000_0000);
    check("R9", cfg_rdata, 32'h0033_3333);

    // R11 same-edge update: open then close segment 2
    cfg_write(4'hF, 32'h0);
    @(negedge clk);
    txn_valid = 1; txn_addr = 32'h0E2000; txn_write = 0;
    cfg_we = 1; cfg_be = 4'hF; cfg_wdata = 32'h0000_0300;
    exp_q.push_back(1'b0); tag_q.push_back("R11");
    @(negedge clk);
    txn_valid = 0; cfg_we = 0; model = 32'h0000_0300;
    txn(32'h0E2000, 0, "R11");
    @(negedge clk);
    txn_valid = 1; txn_addr = 32'h0E2000; txn_write = 1;
    cfg_we = 1; cfg_be = 4'hF; cfg_wdata = 32'h0;
    exp_q.push_back(1'b1); tag_q.push_back("R11");
    @(negedge clk);
    txn_valid = 0; cfg_we = 0; model = 32'h0;
    txn(32'h0E2000, 1, "R11");

    // R10 back-to-back requests
    cfg_write(4'hF, 32'h0000_0100);
    @(negedge clk);
    txn_valid = 1; txn_addr = 32'h0E0000; txn_write = 0;
    exp_q.push_back(1'b1); tag_q.push_back("R10");
    @(negedge clk);
    txn_write = 1;
    exp_q.push_back(1'b0); tag_q.push_back("R10");
    @(negedge clk);
    txn_valid = 0;
    @(negedge clk);
    check("R10", {31'b0, txn_done}, 0);
    check("R10", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule